// File: doc/BRIEF.md
# Single-Line Word-to-Line Bridge Buffer

This block joins a 32-bit word-oriented target port to a memory port that moves only whole 128-byte lines. The memory side can take a long and variable time to answer. The bridge holds one line at a time, together with its tag and two flags: one marks the copy as present, the other marks it as modified.

When a read misses, the bridge fetches the whole line and then returns the addressed word. Later accesses to the same line are served from the buffer with no memory traffic. A write first brings the line in, then merges the enabled bytes of each incoming word into the buffered copy. The modified line goes back to memory as one full-line write in two cases: when the target marks its last write word, or when an access to another line forces the buffer to be replaced.

While a memory operation is outstanding, the target port simply holds its ready low, for as long as that takes.

Top module: `lnbuf_bridge`

## Requirements
- R1: After reset the buffer holds no line and is clean. The first access always causes a memory read request, with no write request before it, and `mem_req_valid` and `tgt_ready` are low while reset is held.
- R2: A read whose line is not buffered issues exactly one read request for that line. It then returns the word selected by address bits [6:2] of the line that memory delivered.
- R3: A read or write to the buffered line is accepted in the same cycle it is presented (`tgt_ready` high while `tgt_valid` is high), with no memory request.
- R4: A write whose line is not buffered first fetches that line. The bytes the write does not enable keep the values memory returned.
- R5: On a write, `tgt_be[i]` enables byte i (bits 8i+7..8i) of `tgt_wdata`. Only the enabled bytes change in the buffered word.
- R6: A write accepted with `tgt_last` high is followed by a full-line write request of the buffer. The line stays buffered and clean, so the next access to it needs no memory request. `tgt_last` has no effect on reads.
- R7: An access that misses while the buffered line is modified writes that line back first, and only then requests the new line.
- R8: Every memory request carries an address whose low 7 bits are zero. Address and direction hold steady until `mem_req_ready` is seen.
- R9: While a memory request or its response is outstanding, `tgt_ready` stays low however many cycles memory takes.
- R10: Address bits [1:0] on the target port do not affect which word is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_valid | input | 1 | Target access presented |
| tgt_ready | output | 1 | Target access accepted this cycle |
| tgt_write | input | 1 | 1 = write, 0 = read |
| tgt_last | input | 1 | Final word of a write transaction |
| tgt_addr | input | ADDR_W | Byte address of the word |
| tgt_wdata | input | 32 | Write data |
| tgt_be | input | 4 | Byte enables for write data |
| tgt_rdata | output | 32 | Read data, valid while tgt_ready is high on a read |
| mem_req_valid | output | 1 | Memory request presented |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_write | output | 1 | 1 = line write, 0 = line read |
| mem_req_addr | output | ADDR_W | Line-aligned address |
| mem_req_line | output | 1024 | Line contents for a write request |
| mem_rsp_valid | input | 1 | Read response line present (one cycle) |
| mem_rsp_line | input | 1024 | Line returned by memory |

## Verification
The hardest situation to reach is a replacement. A modified line must be written back and then a different line fetched, with the target request held the whole time. The stimulus gets there by writing partial byte patterns into one line and then reading a word in another. A logging memory model records the order of its requests, so the bench can confirm that the write came before the read and that the stored old line matches the byte-merged reference. Long and varying latencies in that model keep each request waiting for many cycles, which exercises the stall and the hold of the request.

// File: rtl/lnbuf_pkg.sv
package lnbuf_pkg;
    localparam int WORD_W = 32;
    localparam int BE_W   = WORD_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FREQ,
        ST_FWAIT
    } lb_state_e;

    typedef enum logic {
        NEXT_IDLE,
        NEXT_FETCH
    } lb_after_e;

    typedef struct packed {
        logic wr_en;
        logic mark_dirty;
        logic clear_dirty;
        logic set_line;
        logic cap_tag;
    } lb_ctl_t;

    function automatic logic [WORD_W-1:0] merge_bytes(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [BE_W-1:0]   be
    );
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/lnbuf_store.sv
module lnbuf_store
    import lnbuf_pkg::*;
#(
    parameter int LINE_WORDS = 32
) (
    input  logic                          clk,
    input  logic                          load,
    input  logic [LINE_WORDS*WORD_W-1:0]  load_line,
    input  logic                          wr_en,
    input  logic [$clog2(LINE_WORDS)-1:0] idx,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic [BE_W-1:0]               wr_be,
    output logic [WORD_W-1:0]             rd_data,
    output logic [LINE_WORDS*WORD_W-1:0]  line_out
);
    localparam int IDX_W = $clog2(LINE_WORDS);

    logic [WORD_W-1:0] words [LINE_WORDS];

    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (load) begin
                words[g] <= load_line[g*WORD_W +: WORD_W];
            end else if (wr_en && idx == IDX_W'(g)) begin
                words[g] <= merge_bytes(words[g], wr_data, wr_be);
            end
        end
        assign line_out[g*WORD_W +: WORD_W] = words[g];
    end

    assign rd_data = words[idx];
endmodule

// File: rtl/lnbuf_tag.sv
module lnbuf_tag #(
    parameter int TAG_W = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_line,
    input  logic             mark_dirty,
    input  logic             clear_dirty,
    input  logic [TAG_W-1:0] new_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             hit,
    output logic             dirty,
    output logic [TAG_W-1:0] tag_q
);
    logic valid_q;
    logic dirty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            dirty_q <= 1'b0;
            tag_q   <= '0;
        end else if (set_line) begin
            valid_q <= 1'b1;
            dirty_q <= 1'b0;
            tag_q   <= new_tag;
        end else if (clear_dirty) begin
            dirty_q <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q <= 1'b1;
        end
    end

    assign hit   = valid_q && (tag_q == probe_tag);
    assign dirty = dirty_q;
endmodule

// File: rtl/lnbuf_ctrl.sv
module lnbuf_ctrl
    import lnbuf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tgt_valid,
    input  logic    tgt_write,
    input  logic    tgt_last,
    input  logic    hit,
    input  logic    dirty,
    input  logic    mem_req_ready,
    input  logic    mem_rsp_valid,
    output logic    tgt_ready,
    output logic    mem_req_valid,
    output logic    mem_req_write,
    output lb_ctl_t ctl
);
    lb_state_e st_q, st_d;
    lb_after_e after_q, after_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            after_q <= NEXT_IDLE;
        end else begin
            st_q    <= st_d;
            after_q <= after_d;
        end
    end

    always_comb begin
        st_d          = st_q;
        after_d       = after_q;
        ctl           = '0;
        tgt_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (tgt_valid) begin
                    if (hit) begin
                        tgt_ready = 1'b1;
                        if (tgt_write) begin
                            ctl.wr_en      = 1'b1;
                            ctl.mark_dirty = 1'b1;
                            if (tgt_last) begin
                                st_d    = ST_WBACK;
                                after_d = NEXT_IDLE;
                            end
                        end
                    end else begin
                        ctl.cap_tag = 1'b1;
                        if (dirty) begin
                            st_d    = ST_WBACK;
                            after_d = NEXT_FETCH;
                        end else begin
                            st_d = ST_FREQ;
                        end
                    end
                end
            end
            ST_WBACK: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                if (mem_req_ready) begin
                    ctl.clear_dirty = 1'b1;
                    st_d = (after_q == NEXT_FETCH) ? ST_FREQ : ST_IDLE;
                end
            end
            ST_FREQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) st_d = ST_FWAIT;
            end
            ST_FWAIT: begin
                if (mem_rsp_valid) begin
                    ctl.set_line = 1'b1;
                    st_d         = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/lnbuf_bridge.sv
module lnbuf_bridge
    import lnbuf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  tgt_valid,
    output logic                                  tgt_ready,
    input  logic                                  tgt_write,
    input  logic                                  tgt_last,
    input  logic [ADDR_W-1:0]                     tgt_addr,
    input  logic [31:0]                           tgt_wdata,
    input  logic [3:0]                            tgt_be,
    output logic [31:0]                           tgt_rdata,
    output logic                                  mem_req_valid,
    input  logic                                  mem_req_ready,
    output logic                                  mem_req_write,
    output logic [ADDR_W-1:0]                     mem_req_addr,
    output logic [LINE_BYTES*8-1:0]               mem_req_line,
    input  logic                                  mem_rsp_valid,
    input  logic [LINE_BYTES*8-1:0]               mem_rsp_line
);
    localparam int LINE_WORDS = LINE_BYTES / (WORD_W / 8);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int LSB_W      = $clog2(WORD_W / 8);
    localparam int IDX_W      = $clog2(LINE_WORDS);
    localparam int TAG_W      = ADDR_W - OFF_W;

    lb_ctl_t          ctl;
    logic             hit;
    logic             dirty;
    logic [TAG_W-1:0] tag_q;
    logic [TAG_W-1:0] pend_tag_q;
    logic [TAG_W-1:0] probe_tag;
    logic [IDX_W-1:0] word_idx;
    logic             unused_lsb;

    assign probe_tag  = tgt_addr[ADDR_W-1:OFF_W];
    assign word_idx   = tgt_addr[OFF_W-1:LSB_W];
    assign unused_lsb = ^tgt_addr[LSB_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)              pend_tag_q <= '0;
        else if (ctl.cap_tag) pend_tag_q <= probe_tag;
    end

    lnbuf_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .tgt_valid     (tgt_valid),
        .tgt_write     (tgt_write),
        .tgt_last      (tgt_last),
        .hit           (hit),
        .dirty         (dirty),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .tgt_ready     (tgt_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .ctl           (ctl)
    );

    lnbuf_tag #(.TAG_W(TAG_W)) u_tag (
        .clk         (clk),
        .rst         (rst),
        .set_line    (ctl.set_line),
        .mark_dirty  (ctl.mark_dirty),
        .clear_dirty (ctl.clear_dirty),
        .new_tag     (pend_tag_q),
        .probe_tag   (probe_tag),
        .hit         (hit),
        .dirty       (dirty),
        .tag_q       (tag_q)
    );

    lnbuf_store #(.LINE_WORDS(LINE_WORDS)) u_store (
        .clk       (clk),
        .load      (ctl.set_line),
        .load_line (mem_rsp_line),
        .wr_en     (ctl.wr_en),
        .idx       (word_idx),
        .wr_data   (tgt_wdata),
        .wr_be     (tgt_be),
        .rd_data   (tgt_rdata),
        .line_out  (mem_req_line)
    );

    assign mem_req_addr = {(mem_req_write ? tag_q : pend_tag_q), {OFF_W{1'b0}}};
endmodule

// File: rtl/lnbuf_chk.sv
module lnbuf_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              tgt_valid,
    input logic              tgt_ready,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !mem_req_valid);

    p_line_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_addr[OFF_W-1:0] == '0);

    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

    p_stall_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !tgt_ready);

    p_fetch_line_r2: assert property (@(posedge clk) disable iff (rst)
        tgt_valid && mem_req_valid && !mem_req_write |->
            mem_req_addr[ADDR_W-1:OFF_W] == tgt_addr[ADDR_W-1:OFF_W]);
endmodule

bind lnbuf_bridge lnbuf_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tgt_valid     (tgt_valid),
    .tgt_ready     (tgt_ready),
    .tgt_addr      (tgt_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/tb_lnbuf_bridge.sv
`timescale 1ns/1ps
module tb_lnbuf_bridge;
    localparam int LW   = 1024;
    localparam int NMEM = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tgt_valid = 1'b0, tgt_write = 1'b0, tgt_last = 1'b0;
    logic [31:0] tgt_addr = '0, tgt_wdata = '0;
    logic [3:0]  tgt_be = '0;
    logic        tgt_ready;
    logic [31:0] tgt_rdata;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic [LW-1:0] mem_req_line;
    logic        mem_rsp_valid = 1'b0;
    logic [LW-1:0] mem_rsp_line = '0;

    always #2.5 clk = ~clk;

    lnbuf_bridge dut (
        .clk(clk), .rst(rst),
        .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_write(tgt_write),
        .tgt_last(tgt_last), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .tgt_be(tgt_be), .tgt_rdata(tgt_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_line(mem_req_line), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_line(mem_rsp_line)
    );

    int checks = 0, errors = 0;
    logic [31:0] mem    [NMEM];
    logic [31:0] refmem [NMEM];
    int n_rd = 0, n_wr = 0, n_log = 0;
    logic lg_w    [64];
    int   lg_line [64];
    int lat = 2;
    int cnt = 0, rcnt = 0;
    logic rsp_pend = 1'b0;
    logic [LW-1:0] rsp_buf;
    int unsigned cyc = 0;

    function automatic logic [31:0] init_word(input int i);
        return 32'hA5C3_0000 ^ (i * 32'h0001_0203);
    endfunction

    function automatic logic [31:0] merge_ref(input logic [31:0] o, input logic [31:0] n,
                                              input logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model with programmable latency
    always @(posedge clk) begin
        if (rst) begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            rsp_pend <= 1'b0;
            cnt <= 0;
            rcnt <= 0;
        end else begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                checks++;
                if (mem_req_addr[6:0] != 7'd0) begin
                    errors++;
                    $display("FAIL R8 actual=%h expected=low7 zero", mem_req_addr);
                end
                lg_w[n_log & 63]    = mem_req_write;
                lg_line[n_log & 63] = int'(mem_req_addr[9:7]);
                n_log++;
                cnt <= 0;
                if (mem_req_write) begin
                    n_wr++;
                    for (int i = 0; i < 32; i++)
                        mem[{mem_req_addr[9:7], 5'(i)}] = mem_req_line[32*i +: 32];
                end else begin
                    n_rd++;
                    for (int i = 0; i < 32; i++)
                        rsp_buf[32*i +: 32] = mem[{mem_req_addr[9:7], 5'(i)}];
                    rsp_pend <= 1'b1;
                    rcnt <= 0;
                end
            end else if (mem_req_valid && !rsp_pend) begin
                if (cnt >= lat) mem_req_ready <= 1'b1;
                else cnt <= cnt + 1;
            end
            if (rsp_pend) begin
                if (rcnt >= lat) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_line  <= rsp_buf;
                    rsp_pend <= 1'b0;
                end else rcnt <= rcnt + 1;
            end
        end
    end

    task automatic tgt_op(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] be, input logic last,
                          output logic [31:0] rd, output int stall);
        @(negedge clk);
        tgt_valid = 1'b1; tgt_write = wr; tgt_addr = a;
        tgt_wdata = d; tgt_be = be; tgt_last = last;
        stall = 0;
        #1;
        while (!tgt_ready) begin
            @(negedge clk);
            #1;
            stall++;
        end
        rd = tgt_rdata;
        @(posedge clk);
        #1;
        tgt_valid = 1'b0; tgt_last = 1'b0;
    endtask

    task automatic rd_chk(input logic [31:0] a, input string req, output int stall);
        logic [31:0] rd;
        tgt_op(1'b0, a, 32'h0, 4'h0, 1'b0, rd, stall);
        check(rd == refmem[a[9:2]], req, rd, refmem[a[9:2]]);
    endtask

    task automatic wr_ref(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                          input logic last, output int stall);
        logic [31:0] rd;
        tgt_op(1'b1, a, d, be, last, rd, stall);
        refmem[a[9:2]] = merge_ref(refmem[a[9:2]], d, be);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        int st;
        int rd0;
        logic ok;
        logic [31:0] rd;
        for (int i = 0; i < NMEM; i++) begin
            mem[i] = init_word(i);
            refmem[i] = init_word(i);
        end
        repeat (4) @(posedge clk);
        #1;
        // R1: quiet during reset
        check(mem_req_valid == 1'b0, "R1 reset mem_req_valid", 32'(mem_req_valid), 0);
        check(tgt_ready == 1'b0, "R1 reset tgt_ready", 32'(tgt_ready), 0);
        rst = 1'b0;

        // R1/R2: first read misses, no writeback
        lat = 3;
        rd_chk(32'h104, "R2 miss read data", st);
        check(n_rd == 1, "R1 one fetch", n_rd, 1);
        check(n_wr == 0, "R1 no writeback from reset", n_wr, 0);

        // R3: hits over the whole line
        for (int w = 0; w < 32; w++) begin
            rd_chk(32'h100 + 32'(4*w), "R3 hit read data", st);
            check(st == 0, "R3 hit stall", st, 0);
        end
        check(n_rd == 1, "R3 no new fetch", n_rd, 1);

        // R10: low address bits ignored
        rd_chk(32'h107, "R10 low bits ignored", st);
        rd_chk(32'h102, "R10 low bits ignored", st);

        // R4/R5: write miss, then byte-enable sweep
        for (int w = 0; w < 32; w++) begin
            wr_ref(32'h280 + 32'(4*w), 32'h1122_3344 ^ 32'(w * 32'h0101_0101),
                   4'(w), 1'b0, st);
            if (w == 0) check(n_rd == 2, "R4 write miss fetches", n_rd, 2);
            else        check(st == 0, "R3 write hit stall", st, 0);
        end
        for (int w = 0; w < 32; w++) rd_chk(32'h280 + 32'(4*w), "R5 merged bytes", st);
        check(n_rd == 2 && n_wr == 0, "R4 no extra traffic", n_rd, 2);

        // R7: miss while dirty -> writeback then fetch
        rd_chk(32'h300, "R7 read after replace", st);
        check(n_wr == 1 && n_rd == 3, "R7 one write one read", n_wr, 1);
        check(lg_w[(n_log-2) & 63] == 1'b1 && lg_line[(n_log-2) & 63] == 5,
              "R7 writeback first", 32'(lg_line[(n_log-2) & 63]), 5);
        check(lg_w[(n_log-1) & 63] == 1'b0 && lg_line[(n_log-1) & 63] == 6,
              "R7 fetch second", 32'(lg_line[(n_log-1) & 63]), 6);
        ok = 1'b1;
        for (int w = 0; w < 32; w++) if (mem[160 + w] !== refmem[160 + w]) ok = 1'b0;
        check(ok, "R7 written line contents", 32'(ok), 1);

        // R6: last write flushes, line stays buffered
        wr_ref(32'h30C, 32'hDEAD_BEEF, 4'hF, 1'b1, st);
        while (n_wr < 2) @(negedge clk);
        check(mem[195] == 32'hDEAD_BEEF, "R6 flushed word", mem[195], 32'hDEAD_BEEF);
        tgt_op(1'b0, 32'h30C, 32'h0, 4'h0, 1'b1, rd, st);
        check(rd == 32'hDEAD_BEEF, "R6 read after flush", rd, 32'hDEAD_BEEF);
        check(n_rd == 3 && n_wr == 2, "R6 no traffic after flush", n_rd, 3);

        // R9: long latency stall
        lat = 150;
        rd_chk(32'h09C, "R9 slow read data", st);
        check(st >= 150, "R9 stall length", st, 150);

        // sweep every line with mixed reads, partial writes and a closing write
        for (int L = 0; L < 8; L++) begin
            lat = (L * 7) % 20;
            for (int w = 0; w < 32; w++) begin
                if (w % 3 == 0)
                    rd_chk(32'(L*128 + 4*w), "R2 sweep read", st);
                else
                    wr_ref(32'(L*128 + 4*w), 32'(L * 32'h0F0F_1357 + w * 32'h0003_0507),
                           4'((w + L) % 16), (w == 31), st);
            end
        end
        rd0 = n_rd;
        rd_chk(32'h3FC, "R6 final hit", st);
        check(n_rd == rd0, "R6 final hit no fetch", n_rd, rd0);
        for (int i = 0; i < NMEM; i++)
            check(mem[i] === refmem[i], "R6 memory image", mem[i], refmem[i]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule